// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block adds up the values of coins as they are deposited and raises a one-cycle dispense pulse once the running sum reaches the price of an item. A four-state controller (clear, wait, add, dispense) sequences a small datapath. The datapath holds a captured coin value, a running-total register, a saturating adder and a less-than comparator against the price input.

Each coin arrives as a one-cycle strobe with its value alongside. The value is captured when the strobe is seen in the wait state. It is added to the total in the following cycle. The price is compared live whenever the controller waits without a coin. After a sale the total is cleared, so the next item needs its full price again. Validating coins, returning change, programming prices and driving a display are left to the surroundings.

Top module: `coin_vend_ctrl`

## Requirements
- R1: While `rst` is high, and after its release, `vend_o` is 0. With a nonzero price and no coins, `vend_o` stays 0.
- R2: A `coin_stb` pulse seen while the controller waits adds the `coin_val` present with it to the running total.
- R3: While the total is below `item_cost`, `vend_o` stays 0.
- R4: The final coin strobe can bring the total to `item_cost` or above. Counting the clock edge that samples that strobe as edge 0, `vend_o` is 1 after edge 3 and 0 again after edge 4. It is high for exactly one cycle.
- R5: After a dispense the total is 0, so coins deposited earlier count toward no later sale.
- R6: The total saturates at all ones (255 for 8 bits) instead of wrapping. Example: 200 + 100 with a price of 255 dispenses.
- R7: A strobe that arrives in the cycle right after an accepted strobe is ignored, because the controller is in its add cycle then.
- R8: In the wait state a coin strobe takes priority over the price comparison. A coin arriving when the total already meets the price is added first, and the dispense follows on the R4 timing.
- R9: `item_cost` is compared live. If the price drops to the current total or below during idle waiting, `vend_o` rises after the second edge that sees the new price and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| coin_stb | input | 1 | One-cycle strobe per deposited coin |
| coin_val | input | W (8) | Value of the coin accompanying the strobe |
| item_cost | input | W (8) | Price of the item |
| vend_o | output | 1 | Registered one-cycle dispense pulse |

## Verification
A coin strobe reaches the total after two edges. A dispense decided on that total shows on `vend_o` after edges three and four. A price change that makes an idle total sufficient shows after two edges. The bench drives inputs on falling edges and runs a behavioural model that advances on the same rising edge as the design. It compares `vend_o` with the model at every falling edge, so each result is checked in the exact cycle it is due, neither earlier nor later. Per-scenario pulse counts add a second check that each sale gives exactly one pulse.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    ST_CLR  = 2'd0,
    ST_IDLE = 2'd1,
    ST_ADD  = 2'd2,
    ST_VEND = 2'd3
  } vend_state_e;
endpackage

// File: rtl/vend_datapath.sv
module vend_datapath #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         cap_en_i,
  input  logic         add_en_i,
  input  logic [W-1:0] coin_val,
  input  logic [W-1:0] item_cost,
  output logic         short_o
);
  localparam logic [W-1:0] SAT_MAX = {W{1'b1}};

  logic [W-1:0] cap_q;
  logic [W-1:0] tot_q;
  logic [W:0]   sum_w;
  logic [W-1:0] sat_w;

  assign sum_w = {1'b0, tot_q} + {1'b0, cap_q};
  assign sat_w = sum_w[W] ? SAT_MAX : sum_w[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q <= '0;
      tot_q <= '0;
    end else begin
      if (cap_en_i) cap_q <= coin_val;
      if (clr_i)
        tot_q <= '0;
      else if (add_en_i)
        tot_q <= sat_w;
    end
  end

  assign short_o = (tot_q < item_cost);

  // R5
  total_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (tot_q == '0));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (add_en_i && !clr_i) |=> (tot_q >= $past(tot_q)));
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
  import vend_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic coin_stb,
  input  logic short_i,
  output logic clr_o,
  output logic cap_en_o,
  output logic add_en_o,
  output logic vend_o
);
  vend_state_e st_q, st_d;
  logic        vend_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_CLR:  st_d = ST_IDLE;
      ST_IDLE: begin
        if (coin_stb)     st_d = ST_ADD;
        else if (short_i) st_d = ST_IDLE;
        else              st_d = ST_VEND;
      end
      ST_ADD:  st_d = ST_IDLE;
      ST_VEND: st_d = ST_CLR;
      default: st_d = ST_CLR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_CLR;
      vend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_VEND)     vend_q <= 1'b1;
      else if (st_q == ST_CLR) vend_q <= 1'b0;
    end
  end

  assign clr_o    = (st_q == ST_CLR);
  assign cap_en_o = (st_q == ST_IDLE) && coin_stb;
  assign add_en_o = (st_q == ST_ADD);
  assign vend_o   = vend_q;

  // R4
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    vend_q |=> !vend_q);

  // R7
  add_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ADD) |=> (st_q == ST_IDLE));

  // R8
  coin_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && coin_stb) |=> (st_q == ST_ADD));

  // R3
  no_early_vend_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_IDLE && !coin_stb && short_i) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         coin_stb,
  input  logic [W-1:0] coin_val,
  input  logic [W-1:0] item_cost,
  output logic         vend_o
);
  logic clr_w, cap_en_w, add_en_w, short_w;

  vend_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .coin_stb (coin_stb),
    .short_i  (short_w),
    .clr_o    (clr_w),
    .cap_en_o (cap_en_w),
    .add_en_o (add_en_w),
    .vend_o   (vend_o)
  );

  vend_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_w),
    .cap_en_i  (cap_en_w),
    .add_en_i  (add_en_w),
    .coin_val  (coin_val),
    .item_cost (item_cost),
    .short_o   (short_w)
  );
endmodule

// File: tb/sim_coin_vend_ctrl.sv
module sim_coin_vend_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       coin_stb = 1'b0;
  logic [7:0] coin_val = '0;
  logic [7:0] item_cost = '0;
  logic       vend_o;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state: 0 clear, 1 wait, 2 add, 3 vend
  int m_st = 0;
  int m_tot = 0;
  int m_cap = 0;
  bit m_d = 1'b0;

  always #4 clk = ~clk;

  coin_vend_ctrl #(.W(8)) u0 (
    .clk(clk), .rst(rst), .coin_stb(coin_stb),
    .coin_val(coin_val), .item_cost(item_cost), .vend_o(vend_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_tot <= 0; m_cap <= 0; m_d <= 1'b0;
    end else begin
      case (m_st)
        0: begin m_d <= 1'b0; m_tot <= 0; m_st <= 1; end
        1: begin
          if (coin_stb) begin m_cap <= int'(coin_val); m_st <= 2; end
          else if (m_tot < int'(item_cost)) m_st <= 1;
          else m_st <= 3;
        end
        2: begin m_tot <= (m_tot + m_cap > 255) ? 255 : m_tot + m_cap; m_st <= 1; end
        default: begin m_d <= 1'b1; m_st <= 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (vend_o !== m_d) begin
        fails++;
        $display("FAIL %s: vend_o actual %b expected %b at %0t", tag, vend_o, m_d, $time);
      end
      if (vend_o === 1'b1) pulses++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic coin(input int v);
    @(negedge clk);
    coin_stb = 1'b1; coin_val = 8'(v);
    @(negedge clk);
    coin_stb = 1'b0;
    idle(2);
  endtask

  task automatic expect_pulses(input string req, input int exp);
    checks++;
    if (pulses != exp) begin
      fails++;
      $display("FAIL %s: pulses actual %0d expected %0d", req, pulses, exp);
    end
    pulses = 0;
  endtask

  initial begin
    item_cost = 8'd50;
    idle(3);
    tag = "R1";
    checks++;
    if (vend_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset vend_o actual %b expected 0", vend_o);
    end
    rst = 1'b0;
    idle(10);
    expect_pulses("R1", 0);

    tag = "R3"; coin(20); coin(20); idle(4);
    expect_pulses("R3", 0);
    tag = "R4"; coin(10); idle(6);
    expect_pulses("R4", 1);
    tag = "R2"; expect_pulses("R2", 0);

    tag = "R5"; coin(30); idle(6);
    expect_pulses("R5", 0);
    coin(20); idle(6);
    expect_pulses("R5", 1);

    tag = "R6"; item_cost = 8'd255;
    coin(200); coin(100); idle(6);
    expect_pulses("R6", 1);

    tag = "R7"; item_cost = 8'd40;
    @(negedge clk); coin_stb = 1'b1; coin_val = 8'd20;
    @(negedge clk); coin_val = 8'd20;
    @(negedge clk); coin_stb = 1'b0;
    idle(6);
    expect_pulses("R7", 0);
    coin(20); idle(6);
    expect_pulses("R7", 1);

    tag = "R8"; item_cost = 8'd100;
    coin(60); idle(3);
    @(negedge clk); item_cost = 8'd50; coin_stb = 1'b1; coin_val = 8'd5;
    @(negedge clk); coin_stb = 1'b0;
    idle(6);
    expect_pulses("R8", 1);

    tag = "R9"; item_cost = 8'd100;
    coin(60); idle(5);
    expect_pulses("R9", 0);
    item_cost = 8'd60; idle(6);
    expect_pulses("R9", 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule